// File: doc/BRIEF.md
# MMU Abort Priority Encoder and Fault Capture

This block sits beside the translation and protection logic of a processor memory unit. During one memory access several abort conditions may be raised at once: a misaligned address, a bus error while walking the page tables, a missing translation, a domain violation, a permission violation, or a bus error on the data transfer itself. The block resolves them with a fixed ranking. It then records one 4-bit status code, the 4-bit domain number where that code carries one, and, for data-side aborts, the faulting address.

The requesting logic presents a strobe, a fetch/data flag and six source flags. Each source flag has a qualifier bit that tells a page from a section, or a second-level walk from a first-level one. The requester also presents the domain number and the virtual address of the first aborted word. Data-side and fetch-side results go to separate capture banks. Each bank has a sticky valid flag. A simple write port lets software load or clear every capture register.

Top module: `mmu_fault_capture`

## Requirements
- R1: Source flags are ranked by bit position, with bit 0 highest: bit0 alignment, bit1 walk bus error, bit2 translation, bit3 domain, bit4 permission, bit5 access bus error. Only the highest-ranked active source is recorded.
- R2: An alignment abort records status 4'b0001 and leaves the domain register unchanged.
- R3: A walk bus error records 4'b1100 when its qualifier is 0 (first level, domain unchanged). It records 4'b1110 when its qualifier is 1 (second level, domain loaded).
- R4: A translation abort records 4'b0101 when its qualifier is 0 (section, domain unchanged). It records 4'b0111 when its qualifier is 1 (page, domain loaded).
- R5: A domain abort records 4'b1001 for a section (qualifier 0) or 4'b1011 for a page (qualifier 1). A permission abort records 4'b1101 or 4'b1111 in the same way. Both load the domain.
- R6: An access bus error records 4'b1000 for a section (qualifier 0) or 4'b1010 for a page (qualifier 1), and loads the domain.
- R7: The domain register of a bank loads `abort_domain` only when the winning source carries a valid domain. Otherwise it holds its value.
- R8: On a strobe with `is_fetch`=0 and at least one source active, the data status, domain and address registers load together one cycle later. With no strobe, or with no active source, they hold.
- R9: On a strobe with `is_fetch`=1, only the fetch status and domain registers load. The data status, domain, address and valid outputs stay unchanged.
- R10: On the fetch side the alignment flag is ignored. A fetch strobe whose only active source is alignment changes nothing.
- R11: Each bank's valid flag is set by a capture and cleared by a write to that bank's status register. When both happen in the same cycle, the capture wins.
- R12: When `wr_en` is high, `wr_sel` picks the register to load from `wr_data`: 0 data status (bits 3:0), 1 data domain (bits 3:0), 2 data address (all bits), 3 fetch status (bits 3:0) and fetch domain (bits 7:4). A capture on the same register in the same cycle takes precedence.
- R13: While reset is applied, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| abort_strobe | input | 1 | An access has finished with the source flags valid |
| is_fetch | input | 1 | 1 for an instruction prefetch, 0 for a data access |
| abort_src | input | 6 | Abort source flags, ranked by bit position |
| abort_qual | input | 6 | Per-source page/second-level qualifier |
| abort_domain | input | 4 | Domain number of the access |
| abort_addr | input | 32 | Virtual address of the first aborted word |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| d_status | output | 4 | Data-side fault status |
| d_domain | output | 4 | Data-side fault domain |
| d_addr | output | 32 | Data-side fault address |
| d_valid | output | 1 | Sticky data-side capture flag |
| i_status | output | 4 | Fetch-side fault status |
| i_domain | output | 4 | Fetch-side fault domain |
| i_valid | output | 1 | Sticky fetch-side capture flag |

## Verification
The assertions take for granted that the source flags, qualifiers, domain and address are stable and meaningful in any cycle where `abort_strobe` is high. They also take for granted that no write is in progress when they check that a register holds. The hold and alignment properties are therefore qualified with `wr_en` low. The bench keeps to these conditions: all inputs change only on the falling edge, and the exhaustive sweep over every source and qualifier combination on both sides runs with the write port idle. Write and capture collisions are driven only in separate directed steps.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
  localparam int NSRC = 6;
  localparam int ST_W = 4;

  typedef enum logic [1:0] {
    SEL_DSTAT = 2'd0,
    SEL_DDOM  = 2'd1,
    SEL_DADDR = 2'd2,
    SEL_ISTAT = 2'd3
  } wsel_e;

  typedef struct packed {
    logic            hit;
    logic [ST_W-1:0] code;
    logic            dom_ok;
  } verdict_t;

  // rank 0 highest; q selects page / second-level form
  function automatic logic [ST_W-1:0] code_of(input int rank, input logic q);
    case (rank)
      0:       code_of = 4'b0001;
      1:       code_of = q ? 4'b1110 : 4'b1100;
      2:       code_of = q ? 4'b0111 : 4'b0101;
      3:       code_of = q ? 4'b1011 : 4'b1001;
      4:       code_of = q ? 4'b1111 : 4'b1101;
      5:       code_of = q ? 4'b1010 : 4'b1000;
      default: code_of = '0;
    endcase
  endfunction

  function automatic logic dom_valid_of(input int rank, input logic q);
    case (rank)
      0:       dom_valid_of = 1'b0;
      1, 2:    dom_valid_of = q;
      default: dom_valid_of = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/mfc_prio_enc.sv
`timescale 1ns/1ps
module mfc_prio_enc
  import mfc_pkg::*;
#(
  parameter bit FETCH_SIDE = 1'b0
) (
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] qual_i,
  output verdict_t        verdict_o
);
  localparam logic [NSRC-1:0] SRC_MASK =
    FETCH_SIDE ? {{(NSRC-1){1'b1}}, 1'b0} : {NSRC{1'b1}};

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] grant;

  assign live = src_i & SRC_MASK;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_rank
      if (g == 0) begin : g_top
        assign grant[g] = live[g];
      end else begin : g_rest
        assign grant[g] = live[g] & ~(|live[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    verdict_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) begin
        verdict_o.hit    = 1'b1;
        verdict_o.code   = code_of(i, qual_i[i]);
        verdict_o.dom_ok = dom_valid_of(i, qual_i[i]);
      end
    end
  end
endmodule

// File: rtl/mfc_capture_bank.sv
`timescale 1ns/1ps
module mfc_capture_bank
  import mfc_pkg::*;
#(
  parameter int DOM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ST_W-1:0]  code_i,
  input  logic             dom_ok_i,
  input  logic [DOM_W-1:0] dom_i,
  input  logic             wr_stat_i,
  input  logic [ST_W-1:0]  stat_wdata_i,
  input  logic             wr_dom_i,
  input  logic [DOM_W-1:0] dom_wdata_i,
  output logic [ST_W-1:0]  status_o,
  output logic [DOM_W-1:0] dom_o,
  output logic             valid_o
);
  logic [ST_W-1:0]  stat_q, stat_d;
  logic [DOM_W-1:0] dom_q, dom_d;
  logic             valid_q, valid_d;
  logic             stat_en, dom_en, dom_cap;

  always_comb begin
    dom_cap = load_i & dom_ok_i;
    stat_en = load_i | wr_stat_i;
    stat_d  = load_i ? code_i : stat_wdata_i;
    dom_en  = dom_cap | wr_dom_i;
    dom_d   = dom_cap ? dom_i : dom_wdata_i;
    if (load_i)         valid_d = 1'b1;
    else if (wr_stat_i) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      dom_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (dom_en)  dom_q  <= dom_d;
      valid_q <= valid_d;
    end
  end

  assign status_o = stat_q;
  assign dom_o    = dom_q;
  assign valid_o  = valid_q;

  assert_hold_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !wr_stat_i) |=> $stable(status_o));

  assert_capture_sets_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> valid_o);

  assert_dom_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !dom_ok_i && !wr_dom_i) |=> $stable(dom_o));
endmodule

// File: rtl/mmu_fault_capture.sv
`timescale 1ns/1ps
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int DOM_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort_strobe,
  input  logic                 is_fetch,
  input  logic [NSRC-1:0]      abort_src,
  input  logic [NSRC-1:0]      abort_qual,
  input  logic [DOM_W-1:0]     abort_domain,
  input  logic [ADDR_W-1:0]    abort_addr,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [ADDR_W-1:0]    wr_data,
  output logic [ST_W-1:0]      d_status,
  output logic [DOM_W-1:0]     d_domain,
  output logic [ADDR_W-1:0]    d_addr,
  output logic                 d_valid,
  output logic [ST_W-1:0]      i_status,
  output logic [DOM_W-1:0]     i_domain,
  output logic                 i_valid
);
  localparam int IDOM_LSB = ST_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  verdict_t d_verdict, i_verdict;

  mfc_prio_enc #(.FETCH_SIDE(1'b0)) u_enc_data (
    .src_i     (abort_src),
    .qual_i    (abort_qual),
    .verdict_o (d_verdict)
  );

  mfc_prio_enc #(.FETCH_SIDE(1'b1)) u_enc_fetch (
    .src_i     (abort_src),
    .qual_i    (abort_qual),
    .verdict_o (i_verdict)
  );

  logic d_load, i_load;
  logic wr_dstat, wr_ddom, wr_daddr, wr_istat;

  always_comb begin
    d_load   = abort_strobe & ~is_fetch & d_verdict.hit;
    i_load   = abort_strobe &  is_fetch & i_verdict.hit;
    wr_dstat = wr_en & (wr_sel == SEL_DSTAT);
    wr_ddom  = wr_en & (wr_sel == SEL_DDOM);
    wr_daddr = wr_en & (wr_sel == SEL_DADDR);
    wr_istat = wr_en & (wr_sel == SEL_ISTAT);
  end

  mfc_capture_bank #(.DOM_W(DOM_W)) u_bank_data (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .load_i       (d_load),
    .code_i       (d_verdict.code),
    .dom_ok_i     (d_verdict.dom_ok),
    .dom_i        (abort_domain),
    .wr_stat_i    (wr_dstat),
    .stat_wdata_i (wr_data[ST_W-1:0]),
    .wr_dom_i     (wr_ddom),
    .dom_wdata_i  (wr_data[DOM_W-1:0]),
    .status_o     (d_status),
    .dom_o        (d_domain),
    .valid_o      (d_valid)
  );

  mfc_capture_bank #(.DOM_W(DOM_W)) u_bank_fetch (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .load_i       (i_load),
    .code_i       (i_verdict.code),
    .dom_ok_i     (i_verdict.dom_ok),
    .dom_i        (abort_domain),
    .wr_stat_i    (wr_istat),
    .stat_wdata_i (wr_data[ST_W-1:0]),
    .wr_dom_i     (wr_istat),
    .dom_wdata_i  (wr_data[IDOM_LSB +: DOM_W]),
    .status_o     (i_status),
    .dom_o        (i_domain),
    .valid_o      (i_valid)
  );

  // data-side fault address, loaded only by data aborts
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = d_load | wr_daddr;
    addr_d  = d_load ? abort_addr : wr_data;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end
  assign d_addr = addr_q;

  assert_fetch_keeps_addr_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (abort_strobe && is_fetch && !wr_en) |=> ($stable(d_addr) && $stable(d_status) && $stable(d_valid)));

  assert_fetch_align_ignored_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (abort_strobe && is_fetch && abort_src == 6'b000001 && !wr_en)
      |=> ($stable(i_status) && $stable(i_valid) && $stable(i_domain)));

  assert_align_code_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (abort_strobe && !is_fetch && abort_src[0] && !wr_en)
      |=> (d_status == 4'b0001 && $stable(d_domain)));

  assert_data_capture_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (abort_strobe && !is_fetch && (|abort_src) && !wr_en)
      |=> (d_valid && d_addr == $past(abort_addr)));
endmodule

// File: tb/mmu_fault_capture_bench.sv
`timescale 1ns/1ps
module mmu_fault_capture_bench;
  logic        clk;
  logic        rst_n;
  logic        abort_strobe, is_fetch;
  logic [5:0]  abort_src, abort_qual;
  logic [3:0]  abort_domain;
  logic [31:0] abort_addr;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [3:0]  d_status, d_domain, i_status, i_domain;
  logic [31:0] d_addr;
  logic        d_valid, i_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [3:0]  m_dst, m_ddom, m_ist, m_idom;
  logic [31:0] m_daddr;
  logic        m_dv, m_iv;

  mmu_fault_capture u_mmu_fault_capture (
    .clk(clk), .rst_n(rst_n), .abort_strobe(abort_strobe), .is_fetch(is_fetch),
    .abort_src(abort_src), .abort_qual(abort_qual), .abort_domain(abort_domain),
    .abort_addr(abort_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .d_status(d_status), .d_domain(d_domain), .d_addr(d_addr), .d_valid(d_valid),
    .i_status(i_status), .i_domain(i_domain), .i_valid(i_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      finish_run();
    end
  end

  // base code per rank, page/second-level adds 2
  function automatic logic [3:0] ref_code(input int k, input logic q);
    logic [3:0] base [6];
    base = '{4'b0001, 4'b1100, 4'b0101, 4'b1001, 4'b1101, 4'b1000};
    return (k == 0) ? base[0] : base[k] + (q ? 4'd2 : 4'd0);
  endfunction

  function automatic string rank_tag(input int k, input int pop);
    if (pop > 1) return "R1";
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic stb, input logic f, input logic [5:0] s, input logic [5:0] q,
                      input logic [3:0] dm, input logic [31:0] ad,
                      input logic we, input logic [1:0] sel, input logic [31:0] wd);
    logic [5:0] eff;
    int k, pop;
    string st_tag;
    abort_strobe = stb; is_fetch = f; abort_src = s; abort_qual = q;
    abort_domain = dm; abort_addr = ad; wr_en = we; wr_sel = sel; wr_data = wd;
    if (we) begin
      case (sel)
        2'd0: begin m_dst = wd[3:0]; m_dv = 1'b0; end
        2'd1: m_ddom = wd[3:0];
        2'd2: m_daddr = wd;
        default: begin m_ist = wd[3:0]; m_idom = wd[7:4]; m_iv = 1'b0; end
      endcase
    end
    eff = f ? (s & 6'b111110) : s;
    k = -1; pop = 0;
    for (int b = 5; b >= 0; b--) if (eff[b]) begin k = b; pop++; end
    st_tag = (k < 0) ? (f ? "R10" : "R8") : rank_tag(k, pop);
    if (stb && k >= 0) begin
      logic dv;
      dv = (k >= 3) || ((k == 1 || k == 2) && q[k]);
      if (f) begin
        m_ist = ref_code(k, q[k]);
        if (dv) m_idom = dm;
        m_iv = 1'b1;
      end else begin
        m_dst = ref_code(k, q[k]);
        if (dv) m_ddom = dm;
        m_daddr = ad;
        m_dv = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(f ? "R9" : st_tag, {28'd0, d_status}, {28'd0, m_dst});
    chk("R7", {28'd0, d_domain}, {28'd0, m_ddom});
    chk(f ? "R9" : "R8", d_addr, m_daddr);
    chk("R11", {31'd0, d_valid}, {31'd0, m_dv});
    chk(f ? st_tag : "R9", {28'd0, i_status}, {28'd0, m_ist});
    chk(f ? "R10" : "R9", {28'd0, i_domain}, {28'd0, m_idom});
    chk("R11", {31'd0, i_valid}, {31'd0, m_iv});
  endtask

  initial begin
    rst_n = 1'b0;
    abort_strobe = 0; is_fetch = 0; abort_src = '0; abort_qual = '0;
    abort_domain = '0; abort_addr = '0; wr_en = 0; wr_sel = '0; wr_data = '0;
    m_dst = '0; m_ddom = '0; m_ist = '0; m_idom = '0; m_daddr = '0; m_dv = 0; m_iv = 0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", {d_status, d_domain, i_status, i_domain, 16'd0}, 32'd0);
    chk("R13", d_addr, 32'd0);
    chk("R13", {30'd0, d_valid, i_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // exhaustive sweep: both sides, all sources, all qualifiers
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 64; s++)
        for (int q = 0; q < 64; q++)
          step(1'b1, f[0], s[5:0], q[5:0], s[3:0] ^ q[5:2],
               32'h4000_0000 + (s << 12) + (q << 2) + f, 1'b0, 2'd0, 32'd0);

    // R8: no strobe, and strobe with no source, both hold
    step(1'b0, 1'b0, 6'b111111, 6'b0, 4'hA, 32'hDEAD_0000, 1'b0, 2'd0, 32'd0);
    step(1'b1, 1'b0, 6'b000000, 6'b0, 4'hB, 32'hDEAD_0004, 1'b0, 2'd0, 32'd0);

    // R12: each write select, R11: status write clears valid
    step(1'b0, 1'b0, 6'b0, 6'b0, 4'h0, 32'h0, 1'b1, 2'd0, 32'h0000_0006);
    step(1'b0, 1'b0, 6'b0, 6'b0, 4'h0, 32'h0, 1'b1, 2'd1, 32'h0000_0009);
    step(1'b0, 1'b0, 6'b0, 6'b0, 4'h0, 32'h0, 1'b1, 2'd2, 32'h1234_5678);
    step(1'b0, 1'b0, 6'b0, 6'b0, 4'h0, 32'h0, 1'b1, 2'd3, 32'h0000_00C3);

    // R11/R12: capture and status write in the same cycle, capture wins
    step(1'b1, 1'b0, 6'b010000, 6'b010000, 4'h5, 32'h0000_2000, 1'b1, 2'd0, 32'h0000_0004);
    step(1'b1, 1'b1, 6'b000100, 6'b000000, 4'h7, 32'h0000_3000, 1'b1, 2'd3, 32'h0000_00F2);
    // R7/R12: domain write with non-domain capture keeps the written domain
    step(1'b1, 1'b0, 6'b000001, 6'b0, 4'hE, 32'h0000_4001, 1'b1, 2'd1, 32'h0000_0003);
    // R12: address write loses to a data capture
    step(1'b1, 1'b0, 6'b100000, 6'b0, 4'h1, 32'h0000_5000, 1'b1, 2'd2, 32'hFFFF_FFFF);
    // R9: address write during a fetch capture takes effect
    step(1'b1, 1'b1, 6'b001000, 6'b0, 4'h2, 32'h0000_6000, 1'b1, 2'd2, 32'hAAAA_5555);

    finish_run();
  end
endmodule